// File: doc/BRIEF.md
# Two-Operand ALU with Condition Codes

This unit executes one two-operand instruction per request. It takes a source value, a destination value, the current condition codes and an operation code, and returns the new destination value, the width the store must use, and new negative, zero, overflow and carry flags. Five operations are supported: add, subtract (destination minus source), bit-clear (destination AND NOT source), bit-set (OR) and exclusive-OR. There is also a move, which in byte mode sign-extends the byte to a full word when the destination is a register.

Each operation runs in word mode or in byte mode. In byte mode all arithmetic and flag generation happens on the low byte. The high byte of a byte store toward memory is the unmodified destination high byte, and the width output tells the store path to write only 8 bits. Operands are captured on a clock edge where the start strobe is high. The results are registered, and a done pulse marks them one cycle later. The register file, memory access and instruction decode sit outside this unit.

Top module: `alu2_core`

## Requirements
- R1: While reset is asserted, and after it is released until the first start, result_o, flags_o, wr_word_o and done_o are all zero.
- R2: On a rising edge with start_i high, the outputs take the new values, and done_o is high for exactly the following cycle. Without start_i, done_o is low and result_o, flags_o and wr_word_o hold their values whatever the inputs do.
- R3: Operation code 0 adds. The result is dst+src modulo the operand width. C is the carry out of the operand's top bit. V is set when both operands have the same sign and the result's sign differs. N is the result's top bit and Z is set when the result is zero. Flag ports carry N, Z, V and C in bits 3, 2, 1 and 0.
- R4: Operation code 1 computes dst-src. C is set when the unsigned source exceeds the unsigned destination (a borrow). V is set when the operand signs differ and the result's sign equals the source's sign. N and Z come from the result.
- R5: Operation codes 2 (dst AND NOT src), 3 (dst OR src) and 4 (dst XOR src) set N and Z from the result, clear V, and pass C through unchanged from flags_i.
- R6: In byte mode (byte_i=1), for every operation except a move to a register, bits 7:0 hold the result of the operation on the low bytes. Bits 15:8 hold dst bits 15:8, wr_word_o is 0, N is bit 7 of the result, and C and V are taken at the byte boundary.
- R7: Operation code 5 moves the source. In word mode the result is src. In byte mode with dst_is_reg_i=1, the result is the source byte sign-extended to 16 bits and wr_word_o is 1. N is the top bit of the operand width, Z is set when the moved value is zero, V is cleared and C is kept.
- R8: Operation codes 6 and 7 return dst unchanged with flags_o equal to flags_i, and wr_word_o equal to the inverse of byte_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Capture the operands and execute |
| op_i | input | 3 | Operation code |
| byte_i | input | 1 | 1 = byte mode, 0 = word mode |
| dst_is_reg_i | input | 1 | Destination is a register |
| src_i | input | 16 | Source operand |
| dst_i | input | 16 | Destination operand |
| flags_i | input | 4 | Current N,Z,V,C |
| result_o | output | 16 | Value to store to the destination |
| wr_word_o | output | 1 | 1 = store 16 bits, 0 = store 8 bits |
| flags_o | output | 4 | New N,Z,V,C |
| done_o | output | 1 | Result valid pulse |

## Verification
The sweep crosses every operation code, both modes, both destination kinds and carry-in set and clear, over operands placed at the signed and unsigned edges of both widths: 0x7F/0x80 and 0x7FFF/0x8000, all-ones, and values whose low byte is zero but whose word is not. These operands catch several likely faults. A byte-mode add that carried from bit 15 would miss the carry at 0xFF+0x01. A subtract with its borrow inverted would report C on 5-3. A logic operation that cleared C would lose the incoming carry. A byte move that always sign-extended would corrupt the high byte of a memory store. After every operation the inputs are scrambled without a start, to catch outputs that follow the inputs instead of holding.

// File: rtl/alu2_pkg.sv
package alu2_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_BIC  = 3'd2,
    OP_BIS  = 3'd3,
    OP_XOR  = 3'd4,
    OP_MOV  = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } cc_t;

endpackage

// File: rtl/alu2_lane.sv
module alu2_lane
  import alu2_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] dst_i,
  input  logic         c_i,
  output logic [W-1:0] res_o,
  output cc_t          cc_o
);

  localparam int MSB = W - 1;

  logic [W:0] sum_w;
  logic [W:0] dif_w;

  always_comb begin
    sum_w   = {1'b0, dst_i} + {1'b0, src_i};
    dif_w   = {1'b0, dst_i} - {1'b0, src_i};
    res_o   = dst_i;
    cc_o.c  = c_i;
    cc_o.v  = 1'b0;
    case (op_i)
      OP_ADD: begin
        res_o  = sum_w[MSB:0];
        cc_o.c = sum_w[W];
        cc_o.v = (src_i[MSB] == dst_i[MSB]) && (sum_w[MSB] != src_i[MSB]);
      end
      OP_SUB: begin
        res_o  = dif_w[MSB:0];
        cc_o.c = dif_w[W];
        cc_o.v = (src_i[MSB] != dst_i[MSB]) && (dif_w[MSB] == src_i[MSB]);
      end
      OP_BIC:  res_o = dst_i & ~src_i;
      OP_BIS:  res_o = dst_i | src_i;
      OP_XOR:  res_o = dst_i ^ src_i;
      OP_MOV:  res_o = src_i;
      default: res_o = dst_i;
    endcase
    cc_o.n = res_o[MSB];
    cc_o.z = ~|res_o;
  end

endmodule

// File: rtl/alu2_pack.sv
module alu2_pack
  import alu2_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int BYTE_W = 8
) (
  input  alu_op_e           op_i,
  input  logic              byte_i,
  input  logic              dst_is_reg_i,
  input  logic [WORD_W-1:0] dst_i,
  input  cc_t               cc_i,
  input  logic [WORD_W-1:0] word_res_i,
  input  cc_t               word_cc_i,
  input  logic [BYTE_W-1:0] byte_res_i,
  input  cc_t               byte_cc_i,
  output logic [WORD_W-1:0] res_o,
  output logic              wr_word_o,
  output cc_t               cc_o
);

  localparam int HI_W = WORD_W - BYTE_W;

  logic rsv_op;
  logic sext_mov;

  always_comb begin
    rsv_op   = (op_i == OP_RSV6) || (op_i == OP_RSV7);
    sext_mov = (op_i == OP_MOV) && dst_is_reg_i;
    if (rsv_op) begin
      res_o     = dst_i;
      cc_o      = cc_i;
      wr_word_o = ~byte_i;
    end else if (!byte_i) begin
      res_o     = word_res_i;
      cc_o      = word_cc_i;
      wr_word_o = 1'b1;
    end else if (sext_mov) begin
      res_o     = {{HI_W{byte_res_i[BYTE_W-1]}}, byte_res_i};
      cc_o      = byte_cc_i;
      wr_word_o = 1'b1;
    end else begin
      res_o     = {dst_i[WORD_W-1:BYTE_W], byte_res_i};
      cc_o      = byte_cc_i;
      wr_word_o = 1'b0;
    end
  end

endmodule

// File: rtl/alu2_core.sv
module alu2_core
  import alu2_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [2:0]        op_i,
  input  logic              byte_i,
  input  logic              dst_is_reg_i,
  input  logic [WORD_W-1:0] src_i,
  input  logic [WORD_W-1:0] dst_i,
  input  logic [3:0]        flags_i,
  output logic [WORD_W-1:0] result_o,
  output logic              wr_word_o,
  output logic [3:0]        flags_o,
  output logic              done_o
);

  localparam int BYTE_W = WORD_W / 2;
  localparam int HI_W   = WORD_W - BYTE_W;

  alu_op_e           op_e;
  cc_t               cc_in;
  logic [WORD_W-1:0] word_res;
  cc_t               word_cc;
  logic [BYTE_W-1:0] byte_res;
  cc_t               byte_cc;
  logic [WORD_W-1:0] res_nxt;
  logic              wr_word_nxt;
  cc_t               cc_nxt;
  logic              load_en;

  assign op_e    = alu_op_e'(op_i);
  assign cc_in   = cc_t'(flags_i);
  assign load_en = start_i;

  alu2_lane #(.W(WORD_W)) u_word_lane (
    .op_i  (op_e),
    .src_i (src_i),
    .dst_i (dst_i),
    .c_i   (cc_in.c),
    .res_o (word_res),
    .cc_o  (word_cc)
  );

  alu2_lane #(.W(BYTE_W)) u_byte_lane (
    .op_i  (op_e),
    .src_i (src_i[BYTE_W-1:0]),
    .dst_i (dst_i[BYTE_W-1:0]),
    .c_i   (cc_in.c),
    .res_o (byte_res),
    .cc_o  (byte_cc)
  );

  alu2_pack #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_pack (
    .op_i         (op_e),
    .byte_i       (byte_i),
    .dst_is_reg_i (dst_is_reg_i),
    .dst_i        (dst_i),
    .cc_i         (cc_in),
    .word_res_i   (word_res),
    .word_cc_i    (word_cc),
    .byte_res_i   (byte_res),
    .byte_cc_i    (byte_cc),
    .res_o        (res_nxt),
    .wr_word_o    (wr_word_nxt),
    .cc_o         (cc_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_o  <= '0;
      wr_word_o <= 1'b0;
      flags_o   <= '0;
      done_o    <= 1'b0;
    end else begin
      if (load_en) begin
        result_o  <= res_nxt;
        wr_word_o <= wr_word_nxt;
        flags_o   <= cc_nxt;
      end
      done_o <= load_en;
    end
  end

  a_r2_done_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> done_o);

  a_r2_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> !done_o);

  a_r2_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> ($stable(result_o) && $stable(flags_o) && $stable(wr_word_o)));

  a_r5_logic_keeps_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && (op_e == OP_BIC || op_e == OP_BIS || op_e == OP_XOR))
      |=> (flags_o[0] == $past(flags_i[0])) && !flags_o[1]);

  a_r6_byte_store_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && byte_i && op_e != OP_RSV6 && op_e != OP_RSV7 &&
     !(op_e == OP_MOV && dst_is_reg_i))
      |=> !wr_word_o && (result_o[WORD_W-1:BYTE_W] == $past(dst_i[WORD_W-1:BYTE_W])));

  a_r7_reg_move_sext: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && byte_i && op_e == OP_MOV && dst_is_reg_i)
      |=> wr_word_o && (result_o[WORD_W-1:BYTE_W] == {HI_W{result_o[BYTE_W-1]}}));

  a_r8_reserved_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && (op_e == OP_RSV6 || op_e == OP_RSV7))
      |=> (result_o == $past(dst_i)) && (flags_o == $past(flags_i)));

endmodule

// File: tb/alu2_core_tb.sv
module alu2_core_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_i;
  logic [2:0]    op_i;
  logic          byte_i;
  logic          dst_is_reg_i;
  logic [WW-1:0] src_i;
  logic [WW-1:0] dst_i;
  logic [3:0]    flags_i;
  logic [WW-1:0] result_o;
  logic          wr_word_o;
  logic [3:0]    flags_o;
  logic          done_o;

  int n_checks = 0;
  int n_errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu2_core #(.WORD_W(WW)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .op_i         (op_i),
    .byte_i       (byte_i),
    .dst_is_reg_i (dst_is_reg_i),
    .src_i        (src_i),
    .dst_i        (dst_i),
    .flags_i      (flags_i),
    .result_o     (result_o),
    .wr_word_o    (wr_word_o),
    .flags_o      (flags_o),
    .done_o       (done_o)
  );

  logic [15:0] vals [16] = '{16'h0000, 16'h0001, 16'h007F, 16'h0080,
                             16'h00FF, 16'h0100, 16'h7FFF, 16'h8000,
                             16'h8001, 16'hFFFF, 16'hFF80, 16'hFF7F,
                             16'h1234, 16'hA5C3, 16'h00FE, 16'h7F00};

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model(input logic [2:0] op, input bit byt, input bit rd,
                       input logic [15:0] s, input logic [15:0] d,
                       input logic [3:0] f, output logic [15:0] r,
                       output logic [3:0] fo, output bit ww);
    int w, mask, sv, dv, rv, full, ss, ds, rs;
    bit n, z, v, c;
    w    = byt ? 8 : 16;
    mask = (1 << w) - 1;
    sv   = int'(s) & mask;
    dv   = int'(d) & mask;
    c    = f[0];
    v    = 1'b0;
    rv   = 0;
    if (op >= 3'd6) begin
      r  = d;
      fo = f;
      ww = !byt;
      return;
    end
    case (op)
      3'd0: begin
        full = sv + dv;
        rv   = full & mask;
        c    = ((full >> w) & 1) != 0;
        ss   = (sv >> (w-1)) & 1;
        ds   = (dv >> (w-1)) & 1;
        rs   = (rv >> (w-1)) & 1;
        v    = (ss == ds) && (rs != ss);
      end
      3'd1: begin
        rv = (dv - sv) & mask;
        c  = sv > dv;
        ss = (sv >> (w-1)) & 1;
        ds = (dv >> (w-1)) & 1;
        rs = (rv >> (w-1)) & 1;
        v  = (ss != ds) && (rs == ss);
      end
      3'd2: rv = dv & ~sv & mask;
      3'd3: rv = dv | sv;
      3'd4: rv = dv ^ sv;
      default: rv = sv;
    endcase
    n = ((rv >> (w-1)) & 1) != 0;
    z = rv == 0;
    fo = {n, z, v, c};
    if (!byt) begin
      r  = rv[15:0];
      ww = 1'b1;
    end else if (op == 3'd5 && rd) begin
      r  = rv[7] ? (16'hFF00 | rv[15:0]) : rv[15:0];
      ww = 1'b1;
    end else begin
      r  = {d[15:8], rv[7:0]};
      ww = 1'b0;
    end
  endtask

  function automatic string op_tag(input logic [2:0] op);
    case (op)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2, 3'd3, 3'd4: return "R5";
      3'd5: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic run_op(input logic [2:0] op, input bit byt, input bit rd,
                        input logic [15:0] s, input logic [15:0] d,
                        input logic [3:0] f);
    logic [15:0] er;
    logic [3:0]  ef;
    bit          ew;
    string       ft, rt;
    logic [15:0] held_r;
    logic [3:0]  held_f;
    logic        held_w;
    model(op, byt, rd, s, d, f, er, ef, ew);
    ft = op_tag(op);
    rt = (byt && op < 3'd6 && !(op == 3'd5 && rd)) ? "R6" : ft;
    @(negedge clk);
    start_i = 1'b1; op_i = op; byte_i = byt; dst_is_reg_i = rd;
    src_i = s; dst_i = d; flags_i = f;
    @(negedge clk);
    start_i = 1'b0;
    src_i = ~s; dst_i = ~d; flags_i = ~f; op_i = op + 3'd3; byte_i = !byt;
    check("R2", "done after start", 32'(done_o), 32'd1);
    check(rt, "result", 32'(result_o), 32'(er));
    check(rt, "write width", 32'(wr_word_o), 32'(ew));
    check(byt ? "R6" : ft, "flags", 32'(flags_o), 32'(ef));
    held_r = result_o; held_f = flags_o; held_w = wr_word_o;
    @(negedge clk);
    check("R2", "done low without start", 32'(done_o), 32'd0);
    check("R2", "held outputs", {12'd0, held_w, held_f, held_r[14:0]} ^ 32'(held_r[15]) << 31,
          {12'd0, wr_word_o, flags_o, result_o[14:0]} ^ 32'(result_o[15]) << 31);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; op_i = '0; byte_i = 1'b0;
    dst_is_reg_i = 1'b0; src_i = '0; dst_i = '0; flags_i = '0;
    repeat (3) @(negedge clk);
    check("R1", "result in reset", 32'(result_o), 32'd0);
    check("R1", "flags in reset", 32'(flags_o), 32'd0);
    check("R1", "done in reset", 32'(done_o), 32'd0);
    check("R1", "width in reset", 32'(wr_word_o), 32'd0);
    rst_n = 1'b1;
    src_i = 16'hFFFF; dst_i = 16'hFFFF; flags_i = 4'hF;
    repeat (2) @(negedge clk);
    check("R1", "result after release", 32'(result_o), 32'd0);
    check("R1", "done after release", 32'(done_o), 32'd0);
    for (int op = 0; op < 8; op++)
      for (int byt = 0; byt < 2; byt++)
        for (int rd = 0; rd < 2; rd++)
          for (int fi = 0; fi < 2; fi++)
            for (int i = 0; i < 16; i++)
              for (int j = 0; j < 16; j++)
                run_op(3'(op), byt[0], rd[0], vals[i], vals[j],
                       fi[0] ? 4'hF : 4'h0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule